// File: doc/BRIEF.md
# Integer Register File with Write-Through Read

This block holds the integer registers of a five-stage in-order core. It has 32 entries of 32 bits, two combinational read ports for the operand fetch of the decode stage, and one write port, clocked on the rising edge, for the retirement stage.

When the decode stage reads a register in the same cycle that the retirement stage is writing it, the read port returns the incoming data rather than the stale contents of the array. A consumer in decode therefore sees a result that is being committed in that very cycle, without any forwarding network.

Entry zero is a constant zero. Writes to it are discarded, and it never takes part in the write-through path. A synchronous active-high reset clears every entry. The block does not forward results from any other pipeline stage.

Top module: `reg_file_wt`

## Requirements
- R1: While reset is high, every entry is cleared on the clock edge. After reset, every index reads zero on both ports until a write occurs.
- R2: When `wr_en` is 1 and `wr_idx` is nonzero, `wr_data` is stored into entry `wr_idx` on the rising clock edge. Both ports return it from the next cycle onward.
- R3: When `wr_en` is 0, the array keeps its contents whatever `wr_idx` and `wr_data` carry. A port whose index matches `wr_idx` in that cycle returns the stored value, not `wr_data`.
- R4: When `wr_en` is 1 and a read index equals a nonzero `wr_idx`, that port outputs `wr_data` in the same cycle, before the edge that stores it.
- R5: Each port decides the write-through on its own index. One port may return `wr_data` while the other returns a stored value, and two ports given the same index return the same data.
- R6: Index 0 reads as zero on either port at all times.
- R7: A write with `wr_idx` equal to 0 leaves entry zero unchanged and produces no write-through. Ports reading index 0 stay at zero both in that cycle and afterwards.
- R8: Read data follows the read index and the array combinationally. A new index presented mid-cycle yields its data before the next clock edge.
- R9: A later write to an entry replaces the earlier value, and other entries are left untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears all entries |
| rd_idx_a | input | 5 | Index for read port A (first source operand) |
| rd_idx_b | input | 5 | Index for read port B (second source operand) |
| rd_data_a | output | 32 | Read data of port A, combinational |
| rd_data_b | output | 32 | Read data of port B, combinational |
| wr_en | input | 1 | Write enable from the retirement stage |
| wr_idx | input | 5 | Destination index of the write |
| wr_data | input | 32 | Data to be written |

## Verification
Some properties are checked on every clock edge:
- the array is clear after reset;
- an enabled write to a nonzero entry lands on the next edge;
- the array is frozen while the enable is low;
- a zero-index write leaves entry zero at zero;
- index 0 reads zero;
- a write-through value equals what the array holds one edge later;
- ports with equal indices agree.

Other behaviours only the bench scenarios can show. These are that a disabled write with a matching index returns the stored value rather than the presented data, that a mid-cycle index change is seen before the edge, and that the ports bypass independently under mixed index patterns. Overwrites of earlier values and a full sweep of all entries are likewise bench-only.

// File: rtl/rfw_pkg.sv
package rfw_pkg;

  localparam int unsigned RF_ENTRIES = 32;
  localparam int unsigned RF_WIDTH   = 32;
  localparam int unsigned RF_PORTS   = 2;

  // Source chosen by a read port
  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_BYPASS = 2'd2
  } rd_src_e;

endpackage

// File: rtl/rfw_storage.sv
module rfw_storage #(
  parameter int unsigned ENTRIES = rfw_pkg::RF_ENTRIES,
  parameter int unsigned WIDTH   = rfw_pkg::RF_WIDTH,
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [IW-1:0]                  wr_idx,
  input  logic [WIDTH-1:0]               wr_data,
  output logic [ENTRIES-1:0][WIDTH-1:0]  regs_o
);

  logic [ENTRIES-1:0][WIDTH-1:0] regs_q;
  logic                          wr_ok;
  logic                          all_clear;

  // entry zero is never a legal destination
  assign wr_ok = wr_en && (wr_idx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(ENTRIES); i++) begin
        regs_q[i] <= '0;
      end
    end else if (wr_ok) begin
      regs_q[wr_idx] <= wr_data;
    end
  end

  assign regs_o    = regs_q;
  assign all_clear = (regs_q == '0);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> all_clear)
    else $error("array not clear after reset");

  // R2
  commit_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != '0) |=> regs_q[$past(wr_idx)] == $past(wr_data))
    else $error("enabled write did not land");

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> regs_q == $past(regs_q))
    else $error("array changed without write enable");

  // R7
  zero_row_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == '0) |=> regs_q[0] == '0)
    else $error("entry zero was modified");

endmodule

// File: rtl/rfw_read_port.sv
module rfw_read_port #(
  parameter int unsigned ENTRIES = rfw_pkg::RF_ENTRIES,
  parameter int unsigned WIDTH   = rfw_pkg::RF_WIDTH,
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ENTRIES-1:0][WIDTH-1:0]  regs_i,
  input  logic [IW-1:0]                  rd_idx,
  input  logic                           wr_en,
  input  logic [IW-1:0]                  wr_idx,
  input  logic [WIDTH-1:0]               wr_data,
  output logic [WIDTH-1:0]               rd_data
);
  import rfw_pkg::*;

  rd_src_e src;

  always_comb begin
    if (rd_idx == '0)                       src = SRC_ZERO;
    else if (wr_en && (wr_idx == rd_idx))   src = SRC_BYPASS;
    else                                    src = SRC_ARRAY;
  end

  always_comb begin
    case (src)
      SRC_BYPASS: rd_data = wr_data;
      SRC_ARRAY:  rd_data = regs_i[rd_idx];
      default:    rd_data = '0;
    endcase
  end

  // R6
  zero_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == '0) |-> rd_data == '0)
    else $error("index zero read nonzero");

  // R4
  bypass_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == rd_idx && rd_idx != '0) |=> regs_i[$past(rd_idx)] == $past(rd_data))
    else $error("write-through value differs from committed value");

  // R8
  array_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && rd_idx != '0) |-> rd_data == regs_i[rd_idx])
    else $error("read does not reflect array contents");

endmodule

// File: rtl/reg_file_wt.sv
module reg_file_wt #(
  parameter int unsigned NUM_REGS = rfw_pkg::RF_ENTRIES,
  parameter int unsigned DATA_W   = rfw_pkg::RF_WIDTH,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned NUM_RD  = rfw_pkg::RF_PORTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_RD-1:0][IDX_W-1:0]    idx_arr;
  logic [NUM_RD-1:0][DATA_W-1:0]   data_arr;

  assign idx_arr[0] = rd_idx_a;
  assign idx_arr[1] = rd_idx_b;
  assign rd_data_a  = data_arr[0];
  assign rd_data_b  = data_arr[1];

  rfw_storage #(.ENTRIES(NUM_REGS), .WIDTH(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .regs_o  (regs)
  );

  for (genvar p = 0; p < int'(NUM_RD); p++) begin : g_rd
    rfw_read_port #(.ENTRIES(NUM_REGS), .WIDTH(DATA_W)) u_port (
      .clk     (clk),
      .rst     (rst),
      .regs_i  (regs),
      .rd_idx  (idx_arr[p]),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_data (data_arr[p])
    );
  end

  // R5
  port_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_idx_a == rd_idx_b) |-> rd_data_a == rd_data_b)
    else $error("ports disagree on the same index");

endmodule

// File: tb/tb_reg_file_wt.sv
module tb_reg_file_wt;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_idx_a, rd_idx_b, wr_idx;
  logic [31:0] rd_data_a, rd_data_b, wr_data;
  logic        wr_en;

  int checks   = 0;
  int failures = 0;

  logic [31:0] model [32];

  int          q_port [$];
  logic [31:0] q_exp  [$];
  string       q_tag  [$];
  event        sample_ev;

  always #5 clk = ~clk;

  reg_file_wt dut (
    .clk(clk), .rst(rst),
    .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  function automatic logic [31:0] expect_rd(input logic [4:0] ri, input logic we,
                                            input logic [4:0] wi, input logic [31:0] wd);
    if (ri == 5'd0) return 32'd0;
    if (we && wi == ri) return wd;
    return model[ri];
  endfunction

  // monitor: pops expected items and compares them with the ports
  initial begin
    forever begin
      @(sample_ev);
      #1;
      while (q_port.size() > 0) begin
        int          p;
        logic [31:0] e, act;
        string       t;
        p = q_port.pop_front();
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        act = (p == 0) ? rd_data_a : rd_data_b;
        checks++;
        if (act !== e) begin
          failures++;
          $display("FAIL %s port %0d actual=%h expected=%h", t, p, act, e);
        end
      end
    end
  end

  // driver: one cycle of stimulus, expected items pushed to the scoreboard
  task automatic step(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                      input logic [4:0] ia, input logic [4:0] ib, input string tag);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd;
    rd_idx_a = ia; rd_idx_b = ib;
    q_port.push_back(0); q_exp.push_back(expect_rd(ia, we, wi, wd)); q_tag.push_back(tag);
    q_port.push_back(1); q_exp.push_back(expect_rd(ib, we, wi, wd)); q_tag.push_back(tag);
    -> sample_ev;
    #2;
    @(posedge clk);
    if (we && wi != 5'd0) model[wi] = wd;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'd0;
    rst = 1'b1; wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'hBAD0_BAD0;
    rd_idx_a = 5'd0; rd_idx_b = 5'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;

    // R1: all entries zero after reset, including 9 targeted during reset
    for (int i = 0; i < 32; i++) step(1'b0, 5'd0, 32'd0, 5'(i), 5'(31 - i), "R1");

    // R4 write-through on port A, R5 port B sees stored value
    step(1'b1, 5'd5, 32'h1111_1111, 5'd5, 5'd6, "R4");
    step(1'b0, 5'd0, 32'd0, 5'd5, 5'd5, "R2");

    // R3 disabled write with matching index
    step(1'b0, 5'd5, 32'hDEAD_BEEF, 5'd5, 5'd7, "R3");
    step(1'b0, 5'd0, 32'd0, 5'd5, 5'd5, "R3");

    // R7 write to entry zero, R6 index zero reads zero
    step(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0, "R7");
    step(1'b0, 5'd0, 32'd0, 5'd0, 5'd5, "R6");

    // R5 write-through only on port B
    step(1'b1, 5'd12, 32'hC0DE_0012, 5'd5, 5'd12, "R5");
    // R4 both ports on the written index
    step(1'b1, 5'd20, 32'h2020_2020, 5'd20, 5'd20, "R4");
    step(1'b0, 5'd0, 32'd0, 5'd12, 5'd20, "R2");

    // R9 overwrite, neighbours untouched
    step(1'b1, 5'd5, 32'h5555_AAAA, 5'd12, 5'd6, "R9");
    step(1'b0, 5'd0, 32'd0, 5'd5, 5'd12, "R9");

    // R8 index change inside one low phase
    @(negedge clk);
    wr_en = 1'b0; rd_idx_a = 5'd5; rd_idx_b = 5'd12;
    #1;
    checks++;
    if (rd_data_a !== 32'h5555_AAAA) begin
      failures++;
      $display("FAIL R8 first index actual=%h expected=%h", rd_data_a, 32'h5555_AAAA);
    end
    rd_idx_a = 5'd20;
    #1;
    checks++;
    if (rd_data_a !== 32'h2020_2020) begin
      failures++;
      $display("FAIL R8 second index actual=%h expected=%h", rd_data_a, 32'h2020_2020);
    end

    // R2 sweep over all entries with per-index patterns
    for (int i = 1; i < 32; i++)
      step(1'b1, 5'(i), (32'(i) * 32'h0101_0101) ^ 32'hA5A5_0000, 5'(i), 5'(i - 1), "R2");
    for (int i = 0; i < 32; i++) step(1'b0, 5'd0, 32'd0, 5'(i), 5'(31 - i), "R2");

    @(negedge clk);
    #4;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule